// File: doc/BRIEF.md
# Guest Entry Precondition Checker

This block decides whether a request to enter a guest virtual machine may go ahead. It looks at the current processor state and returns one verdict per request. The checks are applied in a fixed priority order. Two of the possible verdicts are faults, which are an invalid-opcode fault and a general-protection fault. Two are flag-style failures, which leave control with the next instruction. The last verdict is "proceed". Only the zero-flag failure carries an error code, and that code names the condition that failed.

A request is a single-cycle strobe with the full state presented alongside it. The verdict, the error code, a single-step debug trap indication and a management-mode return indication all appear together on the next cycle, qualified by a one-cycle valid pulse. Between requests the result fields hold their last values and the input pins are not observed. The checker reads the launch-state bit and never changes it.

Top module: `vm_entry_gate`

## Requirements
- R1: While reset is high and on the first cycle after it, res_valid, res_code, err_code, step_trap and mgmt_return are all 0.
- R2: res_valid is 1 on exactly the cycle after each cycle where req is 1, and 0 otherwise.
- R3: If v86_mode or compat_mode is 1, res_code is 1 (invalid-opcode fault) and err_code is 0, whatever the other inputs are.
- R4: If neither mode flag is set and cpl is not 0, res_code is 2 (general-protection fault) and err_code is 0.
- R5: If both mode flags are clear, cpl is 0 and ctl_present is 0, res_code is 3 (carry-flag failure) and err_code is 0.
- R6: If ctl_present is 1 and ss_blocking is 1 (and no earlier check fails), res_code is 4 (zero-flag failure) and err_code is 1. This holds whatever the entry kind and launch state are.
- R7: If is_resume is 0 (launch), ctl_present is 1, ss_blocking is 0 and launch_state is 1 (launched, not clear), res_code is 4 and err_code is 2.
- R8: If is_resume is 1 (resume), ctl_present is 1, ss_blocking is 0 and launch_state is 0 (clear), res_code is 4 and err_code is 3.
- R9: If every check passes, res_code is 0 (proceed) and err_code is 0.
- R10: step_trap is 1 exactly when trap_flag was 1 and res_code is 3 or 4. It is 0 on both faults and on proceed.
- R11: mgmt_return equals in_mgmt AND NOT entry_to_mgmt of the request, independent of the verdict.
- R12: On a cycle with req at 0, all other inputs are ignored. res_code, err_code, step_trap and mgmt_return keep the values of the last request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Entry request strobe, one cycle per request |
| is_resume | input | 1 | Entry kind: 0 launch, 1 resume |
| v86_mode | input | 1 | Virtual-8086 mode active |
| compat_mode | input | 1 | Compatibility mode active |
| cpl | input | 2 | Current privilege level |
| ctl_present | input | 1 | A current control structure exists |
| launch_state | input | 1 | Launch state of the structure: 0 clear, 1 launched |
| ss_blocking | input | 1 | Move-to-stack-segment blocking active |
| trap_flag | input | 1 | Single-step trap flag |
| in_mgmt | input | 1 | Processor is in management mode |
| entry_to_mgmt | input | 1 | Entry-to-management-mode control |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_code | output | 3 | 0 proceed, 1 invalid opcode, 2 general protection, 3 carry-flag failure, 4 zero-flag failure |
| err_code | output | 4 | Failure cause for res_code 4: 1 blocking, 2 launch not clear, 3 resume not launched; otherwise 0 |
| step_trap | output | 1 | Single-step debug trap due |
| mgmt_return | output | 1 | Entry is a return from management mode |

## Verification
The block has only one result register, so a wrong internal decision always shows at the ports. It appears on the cycle right after the request, as a wrong res_code, err_code or trap bit. It also appears as a result field that changes on a cycle without a request. Comparing every output on every clock with an independent model therefore catches a priority inversion, a mis-mapped error value or a leaky hold within one cycle of its cause. The stimulus pits each check against the lower-priority conditions that are active at the same time.

// File: rtl/vme_pkg.sv
package vme_pkg;

    localparam int CPL_W   = 2;
    localparam int ERR_W   = 4;
    localparam int CODE_W  = 3;
    localparam int NCOND   = 3;

    typedef enum logic [CODE_W-1:0] {
        VERDICT_PROCEED = 3'd0,
        VERDICT_UD      = 3'd1,
        VERDICT_GP      = 3'd2,
        VERDICT_CF      = 3'd3,
        VERDICT_ZF      = 3'd4
    } verdict_e;

    // ordered by the priority of the structure checks; value = index + 1
    typedef enum logic [ERR_W-1:0] {
        ERR_NONE         = 4'd0,
        ERR_SS_BLOCK     = 4'd1,
        ERR_LAUNCH_DIRTY = 4'd2,
        ERR_RESUME_FRESH = 4'd3
    } errc_e;

    typedef struct packed {
        logic             is_resume;
        logic             v86;
        logic             compat;
        logic [CPL_W-1:0] cpl;
        logic             ctl_present;
        logic             launched;
        logic             ss_block;
        logic             trap_flag;
        logic             in_mgmt;
        logic             entry_to_mgmt;
    } entry_req_t;

    typedef struct packed {
        verdict_e verdict;
        errc_e    err;
        logic     step_trap;
        logic     mgmt_return;
    } entry_res_t;

    // failures that hand control to the next instruction
    function automatic logic is_flag_failure(verdict_e v);
        return (v == VERDICT_CF) || (v == VERDICT_ZF);
    endfunction

    function automatic logic is_fault(verdict_e v);
        return (v == VERDICT_UD) || (v == VERDICT_GP);
    endfunction

endpackage

// File: rtl/vme_mode_gate.sv
module vme_mode_gate
    import vme_pkg::*;
(
    input  logic             v86,
    input  logic             compat,
    input  logic [CPL_W-1:0] cpl,
    output logic             fault,
    output verdict_e         fault_kind
);

    always_comb begin
        if (v86 || compat) begin
            fault_kind = VERDICT_UD;
        end else if (cpl != '0) begin
            fault_kind = VERDICT_GP;
        end else begin
            fault_kind = VERDICT_PROCEED;
        end
        fault = is_fault(fault_kind);
    end

endmodule

// File: rtl/vme_ctl_check.sv
module vme_ctl_check
    import vme_pkg::*;
(
    input  logic     ctl_present,
    input  logic     is_resume,
    input  logic     launched,
    input  logic     ss_block,
    output verdict_e kind,
    output errc_e    err
);

    logic [NCOND-1:0] hit;
    errc_e            first_err;

    // condition index i reports error value i+1; lower index wins
    assign hit[0] = ss_block;
    assign hit[1] = !is_resume && launched;
    assign hit[2] = is_resume && !launched;

    always_comb begin
        first_err = ERR_NONE;
        for (int i = NCOND - 1; i >= 0; i--) begin
            if (hit[i]) begin
                first_err = errc_e'(ERR_W'(i + 1));
            end
        end
    end

    always_comb begin
        if (!ctl_present) begin
            kind = VERDICT_CF;
            err  = ERR_NONE;
        end else if (|hit) begin
            kind = VERDICT_ZF;
            err  = first_err;
        end else begin
            kind = VERDICT_PROCEED;
            err  = ERR_NONE;
        end
    end

endmodule

// File: rtl/vme_resolve.sv
module vme_resolve
    import vme_pkg::*;
(
    input  logic       mode_fault,
    input  verdict_e   mode_kind,
    input  verdict_e   ctl_kind,
    input  errc_e      ctl_err,
    input  logic       trap_flag,
    input  logic       in_mgmt,
    input  logic       entry_to_mgmt,
    output entry_res_t res
);

    always_comb begin
        if (mode_fault) begin
            res.verdict = mode_kind;
            res.err     = ERR_NONE;
        end else begin
            res.verdict = ctl_kind;
            res.err     = ctl_err;
        end
        res.step_trap   = trap_flag && is_flag_failure(res.verdict);
        res.mgmt_return = in_mgmt && !entry_to_mgmt;
    end

endmodule

// File: rtl/vm_entry_gate.sv
module vm_entry_gate
    import vme_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              is_resume,
    input  logic              v86_mode,
    input  logic              compat_mode,
    input  logic [CPL_W-1:0]  cpl,
    input  logic              ctl_present,
    input  logic              launch_state,
    input  logic              ss_blocking,
    input  logic              trap_flag,
    input  logic              in_mgmt,
    input  logic              entry_to_mgmt,
    output logic              res_valid,
    output logic [CODE_W-1:0] res_code,
    output logic [ERR_W-1:0]  err_code,
    output logic              step_trap,
    output logic              mgmt_return
);

    entry_req_t rq;
    entry_res_t next_res;
    entry_res_t res_q;
    logic       valid_q;
    logic       mode_fault;
    verdict_e   mode_kind;
    verdict_e   ctl_kind;
    errc_e      ctl_err;

    always_comb begin
        rq.is_resume     = is_resume;
        rq.v86           = v86_mode;
        rq.compat        = compat_mode;
        rq.cpl           = cpl;
        rq.ctl_present   = ctl_present;
        rq.launched      = launch_state;
        rq.ss_block      = ss_blocking;
        rq.trap_flag     = trap_flag;
        rq.in_mgmt       = in_mgmt;
        rq.entry_to_mgmt = entry_to_mgmt;
    end

    vme_mode_gate u_mode (
        .v86        (rq.v86),
        .compat     (rq.compat),
        .cpl        (rq.cpl),
        .fault      (mode_fault),
        .fault_kind (mode_kind)
    );

    vme_ctl_check u_ctl (
        .ctl_present (rq.ctl_present),
        .is_resume   (rq.is_resume),
        .launched    (rq.launched),
        .ss_block    (rq.ss_block),
        .kind        (ctl_kind),
        .err         (ctl_err)
    );

    vme_resolve u_res (
        .mode_fault    (mode_fault),
        .mode_kind     (mode_kind),
        .ctl_kind      (ctl_kind),
        .ctl_err       (ctl_err),
        .trap_flag     (rq.trap_flag),
        .in_mgmt       (rq.in_mgmt),
        .entry_to_mgmt (rq.entry_to_mgmt),
        .res           (next_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= req;
            if (req) begin
                res_q <= next_res;
            end
        end
    end

    assign res_valid   = valid_q;
    assign res_code    = res_q.verdict;
    assign err_code    = res_q.err;
    assign step_trap   = res_q.step_trap;
    assign mgmt_return = res_q.mgmt_return;

endmodule

// File: rtl/vme_gate_checker.sv
module vme_gate_checker
    import vme_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              v86_mode,
    input logic              compat_mode,
    input logic              trap_flag,
    input logic              res_valid,
    input logic [CODE_W-1:0] res_code,
    input logic [ERR_W-1:0]  err_code,
    input logic              step_trap,
    input logic              mgmt_return
);

    // R2
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req |=> res_valid);

    // R2
    valid_only_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        !req |=> !res_valid);

    // R3
    mode_fault_first_chk: assert property (@(posedge clk) disable iff (rst)
        (req && (v86_mode || compat_mode)) |=> (res_code == 3'd1 && err_code == 4'd0));

    // R10
    no_trap_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && (res_code == 3'd1 || res_code == 3'd2 || res_code == 3'd0)) |-> !step_trap);

    // R10
    no_trap_without_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !trap_flag) |=> !step_trap);

    // R6
    err_only_on_zf_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_code != 3'd4) |-> (err_code == 4'd0));

    // R12
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req |=> ($stable(res_code) && $stable(err_code) && $stable(step_trap) && $stable(mgmt_return)));

endmodule

bind vm_entry_gate vme_gate_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .req         (req),
    .v86_mode    (v86_mode),
    .compat_mode (compat_mode),
    .trap_flag   (trap_flag),
    .res_valid   (res_valid),
    .res_code    (res_code),
    .err_code    (err_code),
    .step_trap   (step_trap),
    .mgmt_return (mgmt_return)
);

// File: tb/sim_vm_entry_gate.sv
`timescale 1ns/1ps
module sim_vm_entry_gate;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic       is_resume = 1'b0;
    logic       v86_mode = 1'b0;
    logic       compat_mode = 1'b0;
    logic [1:0] cpl = 2'd0;
    logic       ctl_present = 1'b0;
    logic       launch_state = 1'b0;
    logic       ss_blocking = 1'b0;
    logic       trap_flag = 1'b0;
    logic       in_mgmt = 1'b0;
    logic       entry_to_mgmt = 1'b0;
    logic       res_valid;
    logic [2:0] res_code;
    logic [3:0] err_code;
    logic       step_trap;
    logic       mgmt_return;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // model of what the outputs must show after the next edge
    int    exp_valid = 0, exp_code = 0, exp_err = 0, exp_trap = 0, exp_mgmt = 0;
    string exp_tag = "R1";

    always #4 clk = ~clk;   // 125 MHz

    vm_entry_gate u0 (
        .clk(clk), .rst(rst), .req(req), .is_resume(is_resume),
        .v86_mode(v86_mode), .compat_mode(compat_mode), .cpl(cpl),
        .ctl_present(ctl_present), .launch_state(launch_state),
        .ss_blocking(ss_blocking), .trap_flag(trap_flag), .in_mgmt(in_mgmt),
        .entry_to_mgmt(entry_to_mgmt), .res_valid(res_valid), .res_code(res_code),
        .err_code(err_code), .step_trap(step_trap), .mgmt_return(mgmt_return)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R2", "res_valid", int'(res_valid), exp_valid);
        check(exp_tag, "res_code", int'(res_code), exp_code);
        check(exp_tag, "err_code", int'(err_code), exp_err);
        check("R10", "step_trap", int'(step_trap), exp_trap);
        check("R11", "mgmt_return", int'(mgmt_return), exp_mgmt);
    endtask

    // drive one cycle: compare current outputs, then present new inputs
    task automatic step(bit r, bit res, bit v86, bit cm, int pl, bit cp, bit ls,
                        bit ss, bit tf, bit im, bit etm);
        @(negedge clk);
        compare_all();
        req = r; is_resume = res; v86_mode = v86; compat_mode = cm;
        cpl = 2'(pl); ctl_present = cp; launch_state = ls; ss_blocking = ss;
        trap_flag = tf; in_mgmt = im; entry_to_mgmt = etm;
        exp_valid = r ? 1 : 0;
        if (r) begin
            exp_err = 0;
            if (v86 || cm)              begin exp_code = 1; exp_tag = "R3"; end
            else if (pl != 0)           begin exp_code = 2; exp_tag = "R4"; end
            else if (!cp)               begin exp_code = 3; exp_tag = "R5"; end
            else if (ss)                begin exp_code = 4; exp_err = 1; exp_tag = "R6"; end
            else if (!res && ls)        begin exp_code = 4; exp_err = 2; exp_tag = "R7"; end
            else if (res && !ls)        begin exp_code = 4; exp_err = 3; exp_tag = "R8"; end
            else                        begin exp_code = 0; exp_tag = "R9"; end
            exp_trap = (tf && (exp_code == 3 || exp_code == 4)) ? 1 : 0;
            exp_mgmt = (im && !etm) ? 1 : 0;
        end else begin
            exp_tag = "R12";
        end
    endtask

    task automatic idle_noise();
        step(0, 1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 4),
             1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom), 1'($urandom));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs cleared under reset
        check("R1", "res_valid", int'(res_valid), 0);
        check("R1", "res_code", int'(res_code), 0);
        check("R1", "err_code", int'(err_code), 0);
        check("R1", "step_trap", int'(step_trap), 0);
        check("R1", "mgmt_return", int'(mgmt_return), 0);
        rst = 1'b0;
        // R3: mode fault beats everything, even with trap flag set
        step(1, 0, 1, 0, 3, 1, 1, 1, 1, 1, 0);
        step(1, 1, 0, 1, 0, 0, 0, 0, 1, 0, 0);
        // R4: privilege fault, trap set but no trap expected
        step(1, 0, 0, 0, 1, 1, 1, 1, 1, 1, 1);
        step(1, 1, 0, 0, 3, 0, 0, 0, 1, 0, 0);
        // R5: no control structure
        step(1, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        // R6: blocking wins over launch-state checks
        step(1, 0, 0, 0, 0, 1, 1, 1, 1, 0, 0);
        step(1, 1, 0, 0, 0, 1, 0, 1, 0, 0, 0);
        // R7 / R8
        step(1, 0, 0, 0, 0, 1, 1, 0, 1, 1, 0);
        step(1, 1, 0, 0, 0, 1, 0, 0, 1, 1, 1);
        // R9: proceed, trap flag set yet no trap
        step(1, 0, 0, 0, 0, 1, 0, 0, 1, 1, 0);
        step(1, 1, 0, 0, 0, 1, 1, 0, 1, 0, 0);
        // R12: idle cycles with noisy inputs keep last result
        for (int i = 0; i < 6; i++) idle_noise();
        // back-to-back then random mix
        for (int i = 0; i < 400; i++) begin
            if ($urandom % 3 == 0) idle_noise();
            else step(1, 1'($urandom), ($urandom % 6) == 0, ($urandom % 6) == 0,
                      ($urandom % 4 == 0) ? int'($urandom % 4) : 0,
                      ($urandom % 5) != 0, 1'($urandom), ($urandom % 4) == 0,
                      1'($urandom), 1'($urandom), 1'($urandom));
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        compare_all();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule